// File: doc/BRIEF.md
# Pipelined Sideband Read Requester

This block is the requesting half of a graphics-port bus master that reads texture data from system memory. A client hands it read requests (address, burst length, command). The block accepts a request, sends it to the target over a narrow byte-wide sideband channel, and records it in an outstanding-request queue. It does not wait for earlier data to come back before it sends the next request. The request phase and the data phase therefore overlap.

Read data comes back on the wide return path. Each clock carries one 64-bit beat, which stands for the two 32-bit transfers made on the two clock edges. The target returns bursts in the order the requests were issued. The block counts the beats against the burst length at the head of the queue, forwards every beat to the client with a flag on the final beat of each burst, and retires the request at that point. The number of requests that may be in flight is a parameter. The client sees it only as backpressure.

Top module: `texreq_engine`

## Requirements
- R1: While reset is held, `sb_valid` and `dl_valid` are low and `req_ready` is high.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) is sent on `sb_byte` with `sb_valid` high in the five cycles that follow, with no gap. The byte order is: address bits 31:24, then 23:16, then 15:8, then 7:0, then one byte with the length in bits 7:4 and the command in bits 3:0.
- R3: While any of the first four sideband bytes of a request is on the channel, `req_ready` is low. During the fifth byte a new request may be accepted.
- R4: No more than MAX_OUT requests (default 4) are outstanding at once. A request counts as outstanding from its acceptance until its final beat has been received. While MAX_OUT requests are outstanding, `req_ready` is low.
- R5: A new request can be accepted in a cycle in which return data for earlier requests is arriving or being delivered.
- R6: Every return beat (`rd_valid` high) that arrives while at least one request is outstanding appears on `dl_data` with `dl_valid` high one cycle later, with the same data.
- R7: A request with length field L receives exactly L+1 beats. `dl_last` is high on the (L+1)-th delivered beat of each request and on no other beat. Requests are completed in the order they were accepted.
- R8: A return beat that arrives while no request is outstanding is dropped and produces no `dl_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a read request |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 32 | Read address |
| req_len | input | 4 | Burst length minus one |
| req_cmd | input | 4 | Command code, passed on the sideband unchanged |
| sb_valid | output | 1 | Sideband byte is valid |
| sb_byte | output | 8 | Sideband byte |
| rd_valid | input | 1 | Return beat is valid |
| rd_data | input | 64 | Return beat (two 32-bit edge transfers) |
| dl_valid | output | 1 | Delivered beat is valid |
| dl_data | output | 64 | Delivered beat |
| dl_last | output | 1 | Final beat of the current request |

## Verification
Two events can fall in the same cycle: a new request being accepted onto the sideband channel, and a return beat completing and retiring an earlier request, which frees a slot in the outstanding count. The bench provokes this by letting its target answer with short random latencies and random gaps while a stream of requests of random length is issued. It records whether an acceptance ever coincided with return traffic. In every cycle it compares `req_ready` against its own count of accepted minus completed requests and against the sideband byte position. Any mistake in the simultaneous increment and decrement shows up as a wrong ready value, a lost beat or a duplicated beat.

// File: rtl/texreq_pkg.sv
package texreq_pkg;
  localparam int ADDR_W   = 32;
  localparam int LEN_W    = 4;
  localparam int CMD_W    = 4;
  localparam int SB_W     = 8;
  localparam int DATA_W   = 64;
  localparam int RQ_W     = ADDR_W + LEN_W + CMD_W;
  localparam int SB_BEATS = RQ_W / SB_W;
  localparam int IDX_W    = $clog2(SB_BEATS);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [CMD_W-1:0]  cmd;
  } rq_t;

  // byte idx of the packed request, most significant first
  function automatic logic [SB_W-1:0] sb_pick(input rq_t r, input logic [IDX_W-1:0] idx);
    logic [RQ_W-1:0] w;
    w = r;
    return w[RQ_W - SB_W - SB_W*int'(idx) +: SB_W];
  endfunction

  // true when the beat counter sits on the final beat of a burst
  function automatic logic beat_is_final(input logic [LEN_W-1:0] cnt,
                                         input logic [LEN_W-1:0] len);
    return cnt == len;
  endfunction
endpackage

// File: rtl/sb_serializer.sv
module sb_serializer
  import texreq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  rq_t             load_rq,
  output logic            sb_valid,
  output logic [SB_W-1:0] sb_byte,
  output logic            sb_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SB_BEATS - 1);

  logic             busy;
  logic [IDX_W-1:0] idx;
  rq_t              held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      held <= '0;
    end else if (load) begin
      busy <= 1'b1;
      idx  <= '0;
      held <= load_rq;
    end else if (busy) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign sb_valid = busy;
  assign sb_last  = busy && (idx == LAST_IDX);
  assign sb_byte  = busy ? sb_pick(held, idx) : '0;
endmodule

// File: rtl/req_queue.sv
module req_queue
  import texreq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [LEN_W-1:0] head_len,
  output logic             empty,
  output logic             full,
  output logic [OCC_W-1:0] occ
);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

  logic [LEN_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot[i] <= '0;
      else if (push && wr_ptr == PTR_W'(i))        slot[i] <= push_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      if (push && !pop)      occ <= occ + 1'b1;
      else if (pop && !push) occ <= occ - 1'b1;
    end
  end

  assign head_len = slot[rd_ptr];
  assign empty    = (occ == '0);
  assign full     = (occ == OCC_MAX);
endmodule

// File: rtl/beat_tracker.sv
module beat_tracker
  import texreq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LEN_W-1:0]  head_len,
  input  logic              q_empty,
  output logic              take,
  output logic              retire,
  output logic              dl_valid,
  output logic [DATA_W-1:0] dl_data,
  output logic              dl_last
);
  logic [LEN_W-1:0] beat_cnt;
  logic             final_beat;

  assign take       = rd_valid && !q_empty;
  assign final_beat = beat_is_final(beat_cnt, head_len);
  assign retire     = take && final_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      dl_valid <= 1'b0;
      dl_data  <= '0;
      dl_last  <= 1'b0;
    end else begin
      dl_valid <= take;
      dl_last  <= retire;
      if (take) begin
        dl_data  <= rd_data;
        beat_cnt <= final_beat ? '0 : beat_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/texreq_engine.sv
module texreq_engine
  import texreq_pkg::*;
#(
  parameter int MAX_OUT = 4,
  localparam int OCC_W = $clog2(MAX_OUT + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [CMD_W-1:0]  req_cmd,
  output logic              sb_valid,
  output logic [SB_W-1:0]   sb_byte,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dl_valid,
  output logic [DATA_W-1:0] dl_data,
  output logic              dl_last
);
  // named internal events
  logic             accept;
  logic             sb_last;
  logic             q_full, q_empty;
  logic [OCC_W-1:0] occ;
  logic [LEN_W-1:0] head_len;
  logic             take, retire;
  rq_t              new_rq;

  assign new_rq    = '{addr: req_addr, len: req_len, cmd: req_cmd};
  assign req_ready = (!sb_valid || sb_last) && !q_full;
  assign accept    = req_valid && req_ready;

  sb_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_rq(new_rq),
    .sb_valid(sb_valid), .sb_byte(sb_byte), .sb_last(sb_last)
  );

  req_queue #(.DEPTH(MAX_OUT)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(accept), .push_len(req_len),
    .pop(retire), .head_len(head_len), .empty(q_empty), .full(q_full),
    .occ(occ)
  );

  beat_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .head_len(head_len), .q_empty(q_empty), .take(take), .retire(retire),
    .dl_valid(dl_valid), .dl_data(dl_data), .dl_last(dl_last)
  );
endmodule

// File: rtl/texreq_engine_chk.sv
module texreq_engine_chk
  import texreq_pkg::*;
#(
  parameter int MAX_OUT = 4,
  localparam int OCC_W = $clog2(MAX_OUT + 1)
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              sb_valid,
  input logic [SB_W-1:0]   sb_byte,
  input logic              sb_last,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              dl_valid,
  input logic [DATA_W-1:0] dl_data,
  input logic              dl_last,
  input logic [OCC_W-1:0]  occ,
  input logic              q_empty,
  input logic              retire
);
  // R2
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (sb_valid && sb_byte == $past(req_addr[ADDR_W-1 -: SB_W])));
  // R2
  sb_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && !sb_last) |=> sb_valid);
  // R3
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && !sb_last) |-> !req_ready);
  // R4
  occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(MAX_OUT));
  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(MAX_OUT)) |-> !req_ready);
  // R6
  beat_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !q_empty) |=> (dl_valid && dl_data == $past(rd_data)));
  // R7
  last_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (dl_valid && dl_last));
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_last |-> dl_valid);
  // R8
  stray_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid || q_empty) |=> !dl_valid);
endmodule

bind texreq_engine texreq_engine_chk #(.MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .sb_valid(sb_valid), .sb_byte(sb_byte),
  .sb_last(sb_last), .rd_valid(rd_valid), .rd_data(rd_data),
  .dl_valid(dl_valid), .dl_data(dl_data), .dl_last(dl_last),
  .occ(occ), .q_empty(q_empty), .retire(retire)
);

// File: tb/test_texreq_engine.sv
module test_texreq_engine;
  import texreq_pkg::*;

  localparam int MAXO = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [3:0]  req_cmd = '0;
  logic        sb_valid;
  logic [7:0]  sb_byte;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        dl_valid;
  logic [63:0] dl_data;
  logic        dl_last;

  always #4 clk = ~clk;

  texreq_engine #(.MAX_OUT(MAXO)) i_texreq_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_cmd(req_cmd),
    .sb_valid(sb_valid), .sb_byte(sb_byte), .rd_valid(rd_valid),
    .rd_data(rd_data), .dl_valid(dl_valid), .dl_data(dl_data), .dl_last(dl_last)
  );

  typedef struct packed { logic [63:0] d; logic last; } beat_t;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    outstanding = 0;
  int    sb_pos = 0;
  bit    stall = 1'b0;
  bit    overlap_seen = 1'b0;
  bit    done = 1'b0;
  int    lat_max = 6;
  beat_t exp_beats[$];
  rq_t   exp_sb[$];
  rq_t   pend[$];
  logic [39:0] sb_word;

  function automatic logic [63:0] beat_data(input logic [31:0] a, input int b);
    return {a + 32'(b) * 32'd8, a ^ 32'(b) ^ 32'hA5A5_0000};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offers one request and records what must come back
  task automatic send(input logic [31:0] a, input logic [3:0] l, input logic [3:0] c);
    rq_t r;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_cmd = c;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    r = '{addr: a, len: l, cmd: c};
    exp_sb.push_back(r);
    for (int b = 0; b <= int'(l); b++) exp_beats.push_back('{d: beat_data(a, b), last: (b == int'(l))});
    outstanding++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: delivered beats, ready, sideband
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (dl_valid) begin
        if (exp_beats.size() == 0) chk(1'b0, "R8 unexpected beat", dl_data, '0);
        else begin
          beat_t e;
          e = exp_beats.pop_front();
          chk(dl_data == e.d, "R6 data", dl_data, e.d);
          chk(dl_last == e.last, "R7 last flag", 64'(dl_last), 64'(e.last));
          if (dl_last) outstanding--;
        end
      end else begin
        chk(!dl_last, "R7 last without valid", 64'(dl_last), 0);
      end
      begin
        bit exp_rdy;
        exp_rdy = !(sb_valid && sb_pos < 4) && (outstanding < MAXO);
        chk(req_ready == exp_rdy, "R3/R4 ready", 64'(req_ready), 64'(exp_rdy));
      end
      if (req_valid && req_ready && (rd_valid || dl_valid)) overlap_seen = 1'b1;
      if (sb_valid) begin
        sb_word = {sb_word[31:0], sb_byte};
        if (sb_pos == 4) begin
          if (exp_sb.size() == 0) chk(1'b0, "R2 extra sideband", 64'(sb_word), '0);
          else begin
            rq_t e;
            e = exp_sb.pop_front();
            chk(sb_word == e, "R2 sideband bytes", 64'(sb_word), 64'(e));
            pend.push_back(e);
          end
          sb_pos = 0;
        end else sb_pos++;
      end else if (sb_pos != 0) begin
        chk(1'b0, "R2 sideband gap", 64'(sb_pos), 0);
        sb_pos = 0;
      end
    end
  end

  // target model: in-order bursts with random latency and gaps
  initial begin
    rd_valid = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (pend.size() > 0 && !stall) begin
        rq_t r;
        r = pend.pop_front();
        repeat ($urandom_range(0, lat_max)) @(negedge clk);
        for (int b = 0; b <= int'(r.len); b++) begin
          rd_valid = 1'b1; rd_data = beat_data(r.addr, b);
          @(negedge clk);
          if ($urandom_range(0, 3) == 0) begin rd_valid = 1'b0; @(negedge clk); end
        end
        rd_valid = 1'b0;
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 2000 && (exp_beats.size() > 0 || outstanding > 0); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(sb_valid == 1'b0, "R1 sb_valid in reset", 64'(sb_valid), 0);
    chk(dl_valid == 1'b0, "R1 dl_valid in reset", 64'(dl_valid), 0);
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 1);
    @(negedge clk); rst_n = 1'b1;

    // R8: stray beats with nothing outstanding
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rd_valid = 1'b1; rd_data = 64'hDEAD_0000_0000_0000 | 64'(i);
    end
    @(negedge clk); rd_valid = 1'b0;
    #1; chk(dl_valid == 1'b0, "R8 stray beat dropped", 64'(dl_valid), 0);
    repeat (2) @(negedge clk);

    // boundary lengths: single beat and sixteen beats
    send(32'h1234_5678, 4'd0, 4'h3);
    drain();
    send(32'hCAFE_0100, 4'd15, 4'hA);
    drain();

    // R4: fill to the limit with the target stalled
    stall = 1'b1;
    for (int i = 0; i < MAXO; i++) send(32'h0040_0000 + 32'(i) * 32'h100, 4'(i + 1), 4'(i));
    repeat (6) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(req_ready == 1'b0, "R4 ready low at limit", 64'(req_ready), 0);
    end
    stall = 1'b0;
    drain();

    // random stream with short latencies to overlap request and return (R5)
    lat_max = 2;
    for (int i = 0; i < 40; i++)
      send($urandom, 4'($urandom_range(0, 7)), 4'($urandom_range(0, 15)));
    drain();

    chk(overlap_seen, "R5 accept during return traffic", 64'(overlap_seen), 1);
    chk(exp_beats.size() == 0, "R7 all beats returned", 64'(exp_beats.size()), 0);
    chk(outstanding == 0, "R7 all requests retired", 64'(outstanding), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", exp_beats.size());
      summary();
      $finish;
    end
  end
endmodule